// File: doc/BRIEF.md
# Network controller interrupt status unit

This block gathers the interrupt causes of a small Ethernet MAC controller into one status byte and one level interrupt line. Each status bit has its own rule. Receive overrun and transmit-drained are sticky and the host clears them by writing a one to their position in an acknowledge byte. Transmit-done and receive-ready are not stored at all: each is the live "not empty" flag of a small packet-number queue. Allocation-done follows the outcome of the most recent transmit page allocation request.

The block holds two queues of packet numbers. The transmit-completion queue is filled by the transmit logic whenever a frame finishes, whether it succeeded or ended on a fatal error. The host removes its head by acknowledging transmit-done. The receive queue is filled by the receiver and drained by a release pulse from the host. The head of each queue is always visible on an output port. A mask byte written by the host selects which status bits may raise the interrupt. The interrupt output is registered.

Top module: `net_irq_status`

## Requirements
- R1: After reset the status byte, the mask byte and the interrupt output are all zero, both queues are empty and `alloc_fail` is 1.
- R2: Status bit 4 (receive overrun) sets one clock after a pulse on `rx_nomem`, `rx_toolong` or `rx_discard`. It stays set until an acknowledge write with data bit 4 set.
- R3: Status bit 3 (allocation done) takes the value of `alloc_ok` on every `alloc_req` cycle, so a failed request clears it. It holds between requests. `alloc_fail` is always its inverse.
- R4: Status bit 2 (transmit drained) sets one clock after a `tx_drained` pulse. It clears only through an acknowledge write with data bit 2 set.
- R5: A transmit completion pushes `tx_pnum` into the transmit-completion queue. A completion is `tx_ok` or any bit of `tx_fatal` (bit 0 underrun, bit 1 SQE error, bit 2 lost carrier, bit 3 late collision, bit 4 sixteen collisions). Status bit 1 equals "queue not empty" and `tx_head` shows the oldest entry.
- R6: An acknowledge write with data bit 1 set removes the head of the transmit-completion queue. Entries leave in push order. A push while the queue already holds `QDEPTH` (4) entries is dropped.
- R7: An `rx_push` pulse enqueues `rx_pnum` in the receive queue. `rx_pop` removes the head. Status bit 0 equals "receive queue not empty", so it clears only when the queue drains. `rx_head` shows the oldest entry.
- R8: Acknowledge data bits 0, 3, 5, 6 and 7 have no effect on any state.
- R9: `mask_we` loads `wdata` into the mask. `irq` is 1 one clock after the status byte ANDed with the mask becomes non-zero, and 0 one clock after it becomes zero.
- R10: A set event and its acknowledge in the same cycle leave the sticky bit set. A push and a head removal in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_nomem | input | 1 | Receive aborted: buffer allocation failed |
| rx_toolong | input | 1 | Receive aborted: frame over 2048 bytes |
| rx_discard | input | 1 | Receive aborted: discard control bit set |
| alloc_req | input | 1 | Allocation request processed this cycle |
| alloc_ok | input | 1 | Outcome of that request (1 = success) |
| tx_drained | input | 1 | Transmit queue just became empty |
| tx_ok | input | 1 | Transmission completed successfully |
| tx_fatal | input | 5 | Fatal transmit causes (see R5) |
| tx_pnum | input | PNW | Packet number of the finished transmission |
| rx_push | input | 1 | Received packet ready |
| rx_pnum | input | PNW | Packet number of received packet |
| rx_pop | input | 1 | Host releases head of receive queue |
| ack_we | input | 1 | Acknowledge byte write strobe |
| mask_we | input | 1 | Mask byte write strobe |
| wdata | input | 8 | Host write data |
| status | output | 8 | Status byte |
| mask | output | 8 | Current mask byte |
| irq | output | 1 | Level interrupt |
| alloc_fail | output | 1 | Allocation-failed flag |
| tx_head | output | PNW | Head of transmit-completion queue |
| rx_head | output | PNW | Head of receive queue |

## Verification
Two pairs of functions can fall in the same cycle. A sticky bit can be set and acknowledged at once, and a transmit completion can be pushed in the cycle the host acknowledges the head. The bench drives the overrun and drained causes in the same cycle as their acknowledge writes, and expects both bits to stay set. It also pushes a new packet number while acknowledging the only entry. The judgment is that transmit-done stays high and `tx_head` moves to the new number, so neither the push nor the removal was lost.

// File: rtl/net_irq_status.sv
module net_irq_status #(
  parameter int PNW    = 6,
  parameter int QDEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_nomem,
  input  logic           rx_toolong,
  input  logic           rx_discard,
  input  logic           alloc_req,
  input  logic           alloc_ok,
  input  logic           tx_drained,
  input  logic           tx_ok,
  input  logic [4:0]     tx_fatal,
  input  logic [PNW-1:0] tx_pnum,
  input  logic           rx_push,
  input  logic [PNW-1:0] rx_pnum,
  input  logic           rx_pop,
  input  logic           ack_we,
  input  logic           mask_we,
  input  logic [7:0]     wdata,
  output logic [7:0]     status,
  output logic [7:0]     mask,
  output logic           irq,
  output logic           alloc_fail,
  output logic [PNW-1:0] tx_head,
  output logic [PNW-1:0] rx_head
);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(QDEPTH);

  logic           ovr_q, txe_q, alc_q, irq_q;
  logic [7:0]     mask_q;
  logic [PNW-1:0] txq [QDEPTH];
  logic [PNW-1:0] rxq [QDEPTH];
  logic [PW-1:0]  txw, txr, rxw, rxr;
  logic [CW-1:0]  txc, rxc;

  wire ovr_evt = rx_nomem | rx_toolong | rx_discard;
  wire tx_push = (tx_ok | (|tx_fatal)) & (txc != FULL);
  wire tx_pop  = ack_we & wdata[1] & (txc != '0);
  wire rx_in   = rx_push & (rxc != FULL);
  wire rx_out  = rx_pop & (rxc != '0);

  assign status     = {3'b000, ovr_q, alc_q, txe_q, txc != '0, rxc != '0};
  assign mask       = mask_q;
  assign irq        = irq_q;
  assign alloc_fail = ~alc_q;
  assign tx_head    = txq[txr];
  assign rx_head    = rxq[rxr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      txe_q  <= 1'b0;
      alc_q  <= 1'b0;
      irq_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (ovr_evt)                   ovr_q <= 1'b1;
      else if (ack_we && wdata[4])   ovr_q <= 1'b0;
      if (tx_drained)                txe_q <= 1'b1;
      else if (ack_we && wdata[2])   txe_q <= 1'b0;
      if (alloc_req)                 alc_q <= alloc_ok;
      if (mask_we)                   mask_q <= wdata;
      irq_q <= |(status & mask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txw <= '0; txr <= '0; txc <= '0;
      rxw <= '0; rxr <= '0; rxc <= '0;
    end else begin
      if (tx_push) begin
        txq[txw] <= tx_pnum;
        txw <= PW'((32'(txw) + 1) % QDEPTH);
      end
      if (tx_pop) txr <= PW'((32'(txr) + 1) % QDEPTH);
      txc <= txc + CW'(tx_push) - CW'(tx_pop);
      if (rx_in) begin
        rxq[rxw] <= rx_pnum;
        rxw <= PW'((32'(rxw) + 1) % QDEPTH);
      end
      if (rx_out) rxr <= PW'((32'(rxr) + 1) % QDEPTH);
      rxc <= rxc + CW'(rx_in) - CW'(rx_out);
    end
  end

  // R2
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !(ack_we && wdata[4])) |=> status[4]);
  // R3
  alloc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> (status[3] == $past(alloc_ok)) && (alloc_fail != status[3]));
  // R6
  txq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txc <= FULL);
  // R6
  tx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && wdata[1] && txc == 1 && !tx_ok && tx_fatal == '0) |=> !status[1]);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> !irq);
  // R10
  ovr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> status[4]);
endmodule

// File: tb/net_irq_status_tb.sv
module net_irq_status_tb;
  logic clk = 0, rst_n = 0;
  logic rx_nomem = 0, rx_toolong = 0, rx_discard = 0;
  logic alloc_req = 0, alloc_ok = 0, tx_drained = 0, tx_ok = 0;
  logic [4:0] tx_fatal = '0;
  logic [5:0] tx_pnum = '0, rx_pnum = '0;
  logic rx_push = 0, rx_pop = 0, ack_we = 0, mask_we = 0;
  logic [7:0] wdata = '0;
  logic [7:0] status, mask;
  logic irq, alloc_fail;
  logic [5:0] tx_head, rx_head;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  net_irq_status u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic ack(logic [7:0] b);
    ack_we = 1; wdata = b; cyc(); ack_we = 0; wdata = 0;
  endtask

  task automatic txp(logic [5:0] pn, logic ok, logic [4:0] f);
    tx_pnum = pn; tx_ok = ok; tx_fatal = f; cyc(); tx_ok = 0; tx_fatal = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
    chk("R1 status", status, 0); chk("R1 mask", mask, 0);
    chk("R1 irq", irq, 0); chk("R1 alloc_fail", alloc_fail, 1);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 3; i++) begin
      rx_nomem = (i == 0); rx_toolong = (i == 1); rx_discard = (i == 2);
      cyc(); rx_nomem = 0; rx_toolong = 0; rx_discard = 0;
      chk("R2 set", status[4], 1);
      ack(8'hEF); cyc(); cyc();
      chk("R2 hold", status[4], 1);
      ack(8'h10);
      chk("R2 clear", status[4], 0);
    end
  endtask

  task automatic t_alloc();
    alloc_req = 1; alloc_ok = 1; cyc(); alloc_req = 0; alloc_ok = 0;
    chk("R3 ok", status[3], 1); chk("R3 fail flag", alloc_fail, 0);
    cyc(); cyc(); chk("R3 hold", status[3], 1);
    ack(8'h08); chk("R8 ack bit3", status[3], 1);
    alloc_req = 1; alloc_ok = 0; cyc(); alloc_req = 0;
    chk("R3 failed req", status[3], 0); chk("R3 fail flag set", alloc_fail, 1);
  endtask

  task automatic t_drained();
    tx_drained = 1; cyc(); tx_drained = 0;
    chk("R4 set", status[2], 1);
    ack(8'hFB); chk("R4 hold", status[2], 1);
    ack(8'h04); chk("R4 clear", status[2], 0);
  endtask

  task automatic t_txq();
    for (int i = 0; i < 5; i++) begin
      txp(6'(20 + i), 0, 5'(1 << i));
      chk("R5 fatal push", status[1], 1); chk("R5 head", tx_head, 20 + i);
      ack(8'h02); chk("R6 pop", status[1], 0);
    end
    for (int i = 1; i <= 5; i++) txp(6'(i), 1, 0);
    for (int i = 1; i <= 4; i++) begin
      chk("R6 order", tx_head, i); chk("R5 nonempty", status[1], 1);
      ack(8'h02);
    end
    chk("R6 dropped fifth", status[1], 0);
  endtask

  task automatic t_rxq();
    for (int i = 7; i <= 9; i++) begin
      rx_pnum = 6'(i); rx_push = 1; cyc(); rx_push = 0;
    end
    chk("R7 ready", status[0], 1); chk("R7 head", rx_head, 7);
    ack(8'h01); chk("R8 ack bit0", status[0], 1); chk("R8 head kept", rx_head, 7);
    rx_pop = 1; cyc(); rx_pop = 0; chk("R7 next", rx_head, 8);
    chk("R7 still ready", status[0], 1);
    rx_pop = 1; cyc(); cyc(); rx_pop = 1; cyc(); rx_pop = 0;
    chk("R7 drained", status[0], 0);
  endtask

  task automatic t_irq();
    mask_we = 1; wdata = 8'h10; cyc(); mask_we = 0; wdata = 0;
    chk("R9 mask", mask, 8'h10);
    tx_drained = 1; cyc(); tx_drained = 0; cyc();
    chk("R9 unmasked bit", irq, 0);
    rx_discard = 1; cyc(); rx_discard = 0;
    chk("R9 delay", irq, 0); cyc(); chk("R9 raise", irq, 1);
    mask_we = 1; wdata = 8'h00; cyc(); mask_we = 0;
    chk("R9 old mask", irq, 1); cyc(); chk("R9 masked", irq, 0);
    ack(8'h14);
  endtask

  task automatic t_collide();
    rx_nomem = 1; cyc();
    ack_we = 1; wdata = 8'h14; tx_drained = 1; cyc();
    ack_we = 0; wdata = 0; tx_drained = 0; rx_nomem = 0;
    chk("R10 ovr wins", status[4], 1); chk("R10 drained wins", status[2], 1);
    txp(6'd33, 1, 0);
    tx_pnum = 6'd34; tx_ok = 1; ack_we = 1; wdata = 8'h02; cyc();
    tx_ok = 0; ack_we = 0; wdata = 0;
    chk("R10 push+pop level", status[1], 1); chk("R10 push+pop head", tx_head, 34);
    ack(8'h16); chk("R10 all clear", status, 0);
  endtask

  initial begin
    t_reset(); t_overrun(); t_alloc(); t_drained(); t_txq(); t_rxq(); t_irq(); t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule